// File: doc/BRIEF.md
# Masked ADC Channel Scan Sequencer

This block is the SPI master for a 16-bit-word multichannel ADC. The ADC answers each command two frames late. A caller pulses `scanStart` with a channel enable mask. The sequencer then sends one manual conversion command per enabled channel, lowest index first, followed by two all-zero flush words. It throws away the two replies that carry no data yet and matches every later reply to the command it answers. Each result leaves the block as a one-cycle strobe with the channel number, the sample and a tag-mismatch flag. The final result of a scan also carries a last flag.

Two shorter operations use the same frame engine. A single-channel read takes three frames: the command, the same command again as filler, then a zero word whose reply holds the sample. A settings write is one frame. After reset the block configures the converter by itself and is busy until that finishes. The serial clock rate comes from a half-period value in system clocks. Chip select rises after every word.

Top module: `scan_seq_top`

## Requirements
- R1: While reset is held, `csN` is 1, `sclk` is 0, `resValid` and `doneOut` are 0, and `busy` is 1.
- R2: After reset the block sends exactly two frames, 16'h1840 (manual, write, range bit 6) then 16'h4000 (pin-setup command, all pins inputs). It then drops `busy` without pulsing `doneOut`.
- R3: A scan sends, for each set mask bit in ascending order, the word 16'h1000 | (channel << 7), with the channel in bits 10:7. Two 16'h0000 words follow the last command, and no other frames are sent.
- R4: The first two replies of an operation are discarded. Reply k+2 produces the result of command k on `resChan`. Each result is a one-cycle `resValid`, and `resLast` is 1 only on the final one.
- R5: `resSample` is bits 11 down to 12-RES_BITS of the reply word, for RES_BITS of 12, 10 or 8.
- R6: `resTagErr` is 1 exactly when reply bits 15:12 differ from the channel the result belongs to.
- R7: A read of channel c sends 16'h1000|(c<<7) twice, then 16'h0000. It yields one result from the third reply, with `resLast` set.
- R8: A settings write sends the single word 16'h1800 | cfgBits and produces no result.
- R9: Every frame has exactly 16 rising `sclk` edges, MSB first, in SPI mode 0. `csN` goes high between words, and `sclk` is low whenever `csN` is high.
- R10: A `scanStart` that arrives while `busy` is set pulses `overrun` one cycle later. It changes neither the frames sent nor the results.
- R11: A scan with an all-zero mask pulses `doneOut` on the next cycle. It produces no SPI frame and no result.
- R12: Each `sclk` high or low phase lasts `halfPeriod` system clocks, and a value of 0 acts as 1.
- R13: `doneOut` pulses together with the last result, `halfPeriod`+1 clocks after `csN` rises at the end of the final frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanStart | input | 1 | Start a masked scan |
| chanMask | input | NUM_CH | Channel enable mask, sampled with scanStart |
| readStart | input | 1 | Start a single-channel read |
| readChan | input | 4 | Channel for the single read |
| cfgStart | input | 1 | Start a settings write |
| cfgBits | input | 7 | Settings field for the write |
| halfPeriod | input | DIV_W | Serial clock half-period in system clocks |
| busy | output | 1 | An operation is in progress |
| overrun | output | 1 | Scan trigger refused because busy |
| doneOut | output | 1 | Operation finished |
| resValid | output | 1 | Result strobe |
| resChan | output | 4 | Channel of the result |
| resSample | output | RES_BITS | Extracted sample |
| resLast | output | 1 | Final result of the operation |
| resTagErr | output | 1 | Reply tag mismatch |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |

## Verification
The result for command k is due `halfPeriod`+1 clocks after chip select rises at the end of frame k+2. The done strobe arrives in the same cycle as the final result, and the empty-mask done arrives one clock after the trigger. The bench samples every output on the falling clock edge and logs results as they appear. It waits on the count of done strobes rather than on a fixed delay, and under two divider settings it measures the exact distance from the last chip-select rise to done. A behavioural converter model on the SPI pins supplies replies two frames late and logs every word it receives, so command order and flush words are checked at the pins.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int WORD_W = 16;
  localparam int CHAN_W = 4;
  localparam int CFG_W  = 7;

  localparam logic [WORD_W-1:0] CMD_MANUAL = 16'h1000;
  localparam logic [WORD_W-1:0] CMD_WRITE  = 16'h0800;
  localparam logic [WORD_W-1:0] CMD_PINS   = 16'h4000;
  localparam logic [CFG_W-1:0]  SET_RANGE  = 7'h40;

  // strobes from control to the serial engine
  typedef struct packed {
    logic              frameGo;
    logic [WORD_W-1:0] txWord;
  } frameReq_t;

  // completion from the serial engine
  typedef struct packed {
    logic              frameDone;
    logic [WORD_W-1:0] rxWord;
  } frameRsp_t;

  // identity of the command sent in a frame
  typedef struct packed {
    logic              isCmd;
    logic [CHAN_W-1:0] chan;
    logic              last;
  } slotTag_t;

  typedef enum logic [1:0] {OP_INIT, OP_SCAN, OP_READ, OP_CFG} opKind_t;

  function automatic logic [WORD_W-1:0] manualCmd(input logic [CHAN_W-1:0] ch);
    return CMD_MANUAL | {5'b0, ch, 7'b0};
  endfunction
endpackage

// File: rtl/scan_seq_spi.sv
module scan_seq_spi
  import scan_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  frameReq_t        req,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic             miso,
  output frameRsp_t        rsp,
  output logic             sclk,
  output logic             csN,
  output logic             mosi
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  typedef enum logic [1:0] {D_IDLE, D_ACT, D_GAP} spiSt_t;

  spiSt_t            dst;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [BIT_W-1:0]  bitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  halfReg;
  logic              doneR;
  logic              phaseEnd;

  assign phaseEnd = (divCnt == halfReg - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dst     <= D_IDLE;
      txShift <= '0;
      rxShift <= '0;
      bitCnt  <= '0;
      divCnt  <= '0;
      halfReg <= DIV_W'(1);
      sclk    <= 1'b0;
      csN     <= 1'b1;
      doneR   <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (dst)
        D_IDLE: begin
          if (req.frameGo) begin
            txShift <= req.txWord;
            csN     <= 1'b0;
            sclk    <= 1'b0;
            divCnt  <= '0;
            bitCnt  <= '0;
            halfReg <= (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
            dst     <= D_ACT;
          end
        end
        D_ACT: begin
          if (phaseEnd) begin
            divCnt <= '0;
            if (!sclk) begin
              sclk    <= 1'b1;
              rxShift <= {rxShift[WORD_W-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (bitCnt == LAST_BIT) begin
                csN <= 1'b1;
                dst <= D_GAP;
              end else begin
                bitCnt  <= bitCnt + BIT_W'(1);
                txShift <= {txShift[WORD_W-2:0], 1'b0};
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        D_GAP: begin
          if (phaseEnd) begin
            divCnt <= '0;
            doneR  <= 1'b1;
            dst    <= D_IDLE;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: dst <= D_IDLE;
      endcase
    end
  end

  assign mosi          = csN ? 1'b0 : txShift[WORD_W-1];
  assign rsp.frameDone = doneR;
  assign rsp.rxWord    = rxShift;
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                scanStart,
  input  logic [NUM_CH-1:0]   chanMask,
  input  logic                readStart,
  input  logic [CHAN_W-1:0]   readChan,
  input  logic                cfgStart,
  input  logic [CFG_W-1:0]    cfgBits,
  input  frameRsp_t           rsp,
  output frameReq_t           req,
  output logic                busy,
  output logic                overrun,
  output logic                doneOut,
  output logic                resValid,
  output logic [CHAN_W-1:0]   resChan,
  output logic [RES_BITS-1:0] resSample,
  output logic                resLast,
  output logic                resTagErr
);
  localparam int SAMPLE_TOP = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} ctrlSt_t;

  ctrlSt_t           st;
  opKind_t           op;
  logic [NUM_CH-1:0] remMask;
  logic [CHAN_W-1:0] readCh;
  logic [CFG_W-1:0]  cfgReg;
  logic [1:0]        step;
  logic [1:0]        flushLeft;
  slotTag_t          curTag, pipe0, pipe1;
  logic              curFinal;

  logic [CHAN_W-1:0] pick;
  logic [NUM_CH-1:0] remAfter;
  logic [WORD_W-1:0] planWord;
  slotTag_t          planTag;
  logic              planFinal;

  // lowest enabled channel still pending
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (remMask[i]) pick = CHAN_W'(i);
    end
  end

  assign remAfter = remMask & ~(NUM_CH'(1) << pick);

  // word and identity of the next frame
  always_comb begin
    planWord  = '0;
    planTag   = '0;
    planFinal = 1'b0;
    case (op)
      OP_INIT: begin
        if (step == 2'd0) begin
          planWord = CMD_MANUAL | CMD_WRITE | {9'b0, SET_RANGE};
        end else begin
          planWord  = CMD_PINS;
          planFinal = 1'b1;
        end
      end
      OP_SCAN: begin
        if (remMask != '0) begin
          planWord      = manualCmd(pick);
          planTag.isCmd = 1'b1;
          planTag.chan  = pick;
          planTag.last  = (remAfter == '0);
        end else begin
          planFinal = (flushLeft == 2'd1);
        end
      end
      OP_READ: begin
        case (step)
          2'd0: begin
            planWord      = manualCmd(readCh);
            planTag.isCmd = 1'b1;
            planTag.chan  = readCh;
            planTag.last  = 1'b1;
          end
          2'd1:    planWord  = manualCmd(readCh);
          default: planFinal = 1'b1;
        endcase
      end
      OP_CFG: begin
        planWord  = CMD_MANUAL | CMD_WRITE | {9'b0, cfgReg};
        planFinal = 1'b1;
      end
      default: planFinal = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_ISSUE;
      op        <= OP_INIT;
      remMask   <= '0;
      readCh    <= '0;
      cfgReg    <= '0;
      step      <= '0;
      flushLeft <= '0;
      curTag    <= '0;
      curFinal  <= 1'b0;
      pipe0     <= '0;
      pipe1     <= '0;
      overrun   <= 1'b0;
      doneOut   <= 1'b0;
      resValid  <= 1'b0;
      resChan   <= '0;
      resSample <= '0;
      resLast   <= 1'b0;
      resTagErr <= 1'b0;
    end else begin
      overrun  <= 1'b0;
      doneOut  <= 1'b0;
      resValid <= 1'b0;
      resLast  <= 1'b0;
      if (scanStart && st != ST_IDLE) overrun <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (scanStart) begin
            if (chanMask == '0) begin
              doneOut <= 1'b1;
            end else begin
              op        <= OP_SCAN;
              remMask   <= chanMask;
              flushLeft <= 2'd2;
              st        <= ST_ISSUE;
            end
          end else if (readStart) begin
            op     <= OP_READ;
            readCh <= readChan;
            step   <= '0;
            st     <= ST_ISSUE;
          end else if (cfgStart) begin
            op     <= OP_CFG;
            cfgReg <= cfgBits;
            st     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          curTag   <= planTag;
          curFinal <= planFinal;
          step     <= step + 2'd1;
          if (op == OP_SCAN) begin
            if (remMask != '0) remMask <= remAfter;
            else flushLeft <= flushLeft - 2'd1;
          end
          st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp.frameDone) begin
            if (pipe1.isCmd) begin
              resValid  <= 1'b1;
              resChan   <= pipe1.chan;
              resSample <= rsp.rxWord[SAMPLE_TOP -: RES_BITS];
              resTagErr <= (rsp.rxWord[WORD_W-1 -: CHAN_W] != pipe1.chan);
              resLast   <= pipe1.last;
            end
            if (curFinal) begin
              pipe0   <= '0;
              pipe1   <= '0;
              doneOut <= (op != OP_INIT);
              st      <= ST_IDLE;
            end else begin
              pipe1 <= pipe0;
              pipe0 <= curTag;
              st    <= ST_ISSUE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req.frameGo = (st == ST_ISSUE);
  assign req.txWord  = planWord;
  assign busy        = (st != ST_IDLE);
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                scanStart,
  input  logic [NUM_CH-1:0]   chanMask,
  input  logic                readStart,
  input  logic [3:0]          readChan,
  input  logic                cfgStart,
  input  logic [6:0]          cfgBits,
  input  logic [DIV_W-1:0]    halfPeriod,
  output logic                busy,
  output logic                overrun,
  output logic                doneOut,
  output logic                resValid,
  output logic [3:0]          resChan,
  output logic [RES_BITS-1:0] resSample,
  output logic                resLast,
  output logic                resTagErr,
  output logic                sclk,
  output logic                csN,
  output logic                mosi,
  input  logic                miso
);
  frameReq_t req;
  frameRsp_t rsp;

  scan_seq_ctrl #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .scanStart(scanStart), .chanMask(chanMask),
    .readStart(readStart), .readChan(readChan),
    .cfgStart(cfgStart), .cfgBits(cfgBits),
    .rsp(rsp), .req(req),
    .busy(busy), .overrun(overrun), .doneOut(doneOut),
    .resValid(resValid), .resChan(resChan), .resSample(resSample),
    .resLast(resLast), .resTagErr(resTagErr)
  );

  scan_seq_spi #(.DIV_W(DIV_W)) u_spi (
    .clk(clk), .rstN(rstN),
    .req(req), .halfPeriod(halfPeriod), .miso(miso),
    .rsp(rsp), .sclk(sclk), .csN(csN), .mosi(mosi)
  );
endmodule

// File: rtl/scan_seq_checker.sv
module scan_seq_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic busy,
  input logic overrun,
  input logic doneOut,
  input logic resValid,
  input logic resLast
);
  assert_sclk_parked_R9: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_idle_deselected_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  assert_last_needs_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    resLast |-> resValid);

  assert_valid_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_overrun_when_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(busy));

  assert_last_with_done_R13: assert property (@(posedge clk) disable iff (!rstN)
    resLast |-> doneOut);
endmodule

bind scan_seq_top scan_seq_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .busy(busy),
  .overrun(overrun), .doneOut(doneOut), .resValid(resValid), .resLast(resLast)
);

// File: tb/adc_reply_model.sv
module adc_reply_model (
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  input  logic badTag,
  output logic miso
);
  logic [15:0] wordLog [0:511];
  int          count;
  int          badFrames;
  int          bits;
  int          idx;
  logic        seenFall;
  logic [15:0] rxw;
  logic [15:0] reply;

  function automatic logic [11:0] sampleOf(input logic [3:0] ch);
    return 12'(ch) * 12'd273 + 12'h035;
  endfunction

  initial begin
    count = 0; badFrames = 0; bits = 0; idx = 0;
    seenFall = 1'b0; rxw = '0; reply = 16'hFFFF; miso = 1'b0;
  end

  always @(negedge csN) begin
    seenFall = 1'b1;
    bits = 0;
    idx = 14;
    miso = reply[15];
  end

  always @(posedge sclk) if (csN == 1'b0) begin
    rxw = {rxw[14:0], mosi};
    bits++;
  end

  always @(negedge sclk) if (csN == 1'b0) begin
    if (idx >= 0) miso = reply[idx];
    idx--;
  end

  always @(posedge csN) if (seenFall) begin
    logic [15:0] src;
    logic [3:0]  ch;
    if (bits != 16) badFrames++;
    if (count < 512) wordLog[count] = rxw;
    count++;
    reply = 16'hFFFF;
    if (count >= 2) begin
      src = wordLog[count-2];
      if (src[12] && !src[14]) begin
        ch = src[10:7];
        reply = {badTag ? (ch ^ 4'h1) : ch, sampleOf(ch)};
      end
    end
  end
endmodule

// File: tb/tb_scan_seq_top.sv
module tb_scan_seq_top;
  localparam int H = 2;
  localparam logic [15:0] SCAN_MASK [6] = '{16'h0001, 16'h8000, 16'hA5A5, 16'hFFFF, 16'h0110, 16'h7003};
  localparam int          SCAN_NCH  [6] = '{1, 1, 8, 16, 2, 5};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic scanStart, readStart, cfgStart;
  logic [15:0] chanMask;
  logic [3:0]  readChan;
  logic [6:0]  cfgBits;
  logic [7:0]  halfPeriod;
  logic busy, overrun, doneOut, resValid, resLast, resTagErr;
  logic [3:0]  resChan;
  logic [11:0] resSample;
  logic sclk, csN, mosi, miso, badTag;

  logic scanStart8;
  logic [15:0] chanMask8;
  logic busy8, overrun8, doneOut8, resValid8, resLast8, resTagErr8;
  logic [3:0] resChan8;
  logic [7:0] resSample8;
  logic sclk8, csN8, mosi8, miso8;

  scan_seq_top dut (
    .clk(clk), .rstN(rstN), .scanStart(scanStart), .chanMask(chanMask),
    .readStart(readStart), .readChan(readChan), .cfgStart(cfgStart), .cfgBits(cfgBits),
    .halfPeriod(halfPeriod), .busy(busy), .overrun(overrun), .doneOut(doneOut),
    .resValid(resValid), .resChan(resChan), .resSample(resSample), .resLast(resLast),
    .resTagErr(resTagErr), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );
  adc_reply_model mdl (.csN(csN), .sclk(sclk), .mosi(mosi), .badTag(badTag), .miso(miso));

  scan_seq_top #(.RES_BITS(8)) dut8 (
    .clk(clk), .rstN(rstN), .scanStart(scanStart8), .chanMask(chanMask8),
    .readStart(1'b0), .readChan(4'd0), .cfgStart(1'b0), .cfgBits(7'd0),
    .halfPeriod(8'd2), .busy(busy8), .overrun(overrun8), .doneOut(doneOut8),
    .resValid(resValid8), .resChan(resChan8), .resSample(resSample8), .resLast(resLast8),
    .resTagErr(resTagErr8), .sclk(sclk8), .csN(csN8), .mosi(mosi8), .miso(miso8)
  );
  adc_reply_model mdl8 (.csN(csN8), .sclk(sclk8), .mosi(mosi8), .badTag(1'b0), .miso(miso8));

  int nChecks = 0, nFail = 0;
  logic [3:0]  rChan [0:31];
  logic [11:0] rSamp [0:31];
  logic        rLast [0:31];
  logic        rErr  [0:31];
  logic [7:0]  r8Samp [0:31];
  int resCnt = 0, res8Cnt = 0, doneCount = 0, done8Count = 0, ovCount = 0;
  int cyc = 0, csRiseCyc = 0, doneCyc = 0, hiRun = 0, lastHi = 0;
  logic prevCs = 1'b1;

  function automatic logic [11:0] sampleOf(input logic [3:0] ch);
    return 12'(ch) * 12'd273 + 12'h035;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (resValid && resCnt < 32) begin
      rChan[resCnt] = resChan; rSamp[resCnt] = resSample;
      rLast[resCnt] = resLast; rErr[resCnt] = resTagErr;
      resCnt++;
    end
    if (resValid8 && res8Cnt < 32) begin
      r8Samp[res8Cnt] = resSample8;
      res8Cnt++;
    end
    if (doneOut) begin doneCount++; doneCyc = cyc; end
    if (doneOut8) done8Count++;
    if (overrun) ovCount++;
    if (csN && !prevCs) csRiseCyc = cyc;
    prevCs = csN;
    if (sclk) hiRun++;
    else if (hiRun > 0) begin lastHi = hiRun; hiRun = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  task automatic pulseScan();
    @(negedge clk) scanStart = 1'b1;
    @(negedge clk) scanStart = 1'b0;
  endtask

  task automatic waitDoneFrom(input int d0);
    int guard = 0;
    while (doneCount <= d0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    if (guard >= 20000) chk(1'b0, "R13 done timeout", doneCount, d0 + 1);
  endtask

  task automatic runScanCheck(input logic [15:0] m, input int nExp);
    int base = mdl.count;
    int d0 = doneCount;
    int k = 0;
    resCnt = 0;
    chanMask = m;
    pulseScan();
    waitDoneFrom(d0);
    chk(resCnt == nExp, "R4 result count", resCnt, nExp);
    for (int b = 0; b < 16; b++) begin
      if (m[b]) begin
        chk(rChan[k] == 4'(b), "R4 result channel", rChan[k], b);
        chk(rSamp[k] == sampleOf(4'(b)), "R5 sample value", rSamp[k], sampleOf(4'(b)));
        chk(rLast[k] == (k == nExp - 1), "R4 last flag", rLast[k], (k == nExp - 1));
        chk(rErr[k] == 1'b0, "R6 no tag error", rErr[k], 0);
        chk(mdl.wordLog[base+k] == (16'h1000 | (16'(b) << 7)), "R3 command word",
            mdl.wordLog[base+k], 16'h1000 | (16'(b) << 7));
        k++;
      end
    end
    chk(mdl.wordLog[base+nExp] == 16'h0 && mdl.wordLog[base+nExp+1] == 16'h0,
        "R3 flush words", mdl.wordLog[base+nExp+1], 0);
    chk(mdl.count == base + nExp + 2, "R3 frame count", mdl.count - base, nExp + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    int base, d0, ov0, guard;
    rstN = 1'b0; scanStart = 0; readStart = 0; cfgStart = 0;
    chanMask = '0; readChan = '0; cfgBits = '0; halfPeriod = 8'(H); badTag = 0;
    scanStart8 = 0; chanMask8 = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csN == 1'b1, "R1 csN in reset", csN, 1);
    chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
    chk(resValid == 1'b0 && doneOut == 1'b0, "R1 strobes in reset", resValid, 0);
    chk(busy == 1'b1, "R1 busy in reset", busy, 1);
    rstN = 1'b1;

    // R2 init sequence
    guard = 0;
    @(negedge clk);
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    chk(mdl.count == 2, "R2 init frame count", mdl.count, 2);
    chk(mdl.wordLog[0] == 16'h1840, "R2 settings word", mdl.wordLog[0], 16'h1840);
    chk(mdl.wordLog[1] == 16'h4000, "R2 pin setup word", mdl.wordLog[1], 16'h4000);
    chk(doneCount == 0, "R2 no done after init", doneCount, 0);

    // table of scans (R3 R4 R5 R6)
    for (int i = 0; i < 6; i++) runScanCheck(SCAN_MASK[i], SCAN_NCH[i]);
    chk(doneCyc - csRiseCyc == H + 1, "R13 done latency", doneCyc - csRiseCyc, H + 1);

    // R7 single read
    base = mdl.count; d0 = doneCount; resCnt = 0; readChan = 4'd5;
    @(negedge clk) readStart = 1'b1;
    @(negedge clk) readStart = 1'b0;
    waitDoneFrom(d0);
    chk(mdl.count == base + 3, "R7 frame count", mdl.count - base, 3);
    chk(mdl.wordLog[base] == 16'h1280 && mdl.wordLog[base+1] == 16'h1280,
        "R7 repeated command", mdl.wordLog[base+1], 16'h1280);
    chk(mdl.wordLog[base+2] == 16'h0000, "R7 trailing zero", mdl.wordLog[base+2], 0);
    chk(resCnt == 1 && rChan[0] == 4'd5, "R7 one result ch5", resCnt, 1);
    chk(rSamp[0] == sampleOf(4'd5) && rLast[0], "R7 sample and last", rSamp[0], sampleOf(4'd5));

    // R8 settings write
    base = mdl.count; d0 = doneCount; resCnt = 0; cfgBits = 7'h2A;
    @(negedge clk) cfgStart = 1'b1;
    @(negedge clk) cfgStart = 1'b0;
    waitDoneFrom(d0);
    chk(mdl.count == base + 1, "R8 one frame", mdl.count - base, 1);
    chk(mdl.wordLog[base] == 16'h182A, "R8 write word", mdl.wordLog[base], 16'h182A);
    chk(resCnt == 0, "R8 no result", resCnt, 0);

    // R6 tag mismatch
    d0 = doneCount; resCnt = 0; readChan = 4'd3; badTag = 1'b1;
    @(negedge clk) readStart = 1'b1;
    @(negedge clk) readStart = 1'b0;
    waitDoneFrom(d0);
    badTag = 1'b0;
    chk(resCnt == 1 && rErr[0] == 1'b1, "R6 tag error flagged", rErr[0], 1);
    chk(rChan[0] == 4'd3, "R6 expected channel kept", rChan[0], 3);

    // R11 empty mask
    base = mdl.count; d0 = doneCount; resCnt = 0; chanMask = '0;
    pulseScan();
    @(negedge clk);
    chk(doneCount == d0 + 1, "R11 immediate done", doneCount, d0 + 1);
    repeat (40) @(negedge clk);
    chk(mdl.count == base, "R11 no frames", mdl.count - base, 0);
    chk(resCnt == 0 && !busy, "R11 no results idle", resCnt, 0);

    // R10 overrun
    ov0 = ovCount; base = mdl.count; d0 = doneCount; resCnt = 0; chanMask = 16'hFFFF;
    pulseScan();
    repeat (20) @(negedge clk);
    chanMask = 16'h0003;
    pulseScan();
    waitDoneFrom(d0);
    chk(ovCount == ov0 + 1, "R10 overrun pulse", ovCount - ov0, 1);
    chk(mdl.count == base + 18, "R10 frames unchanged", mdl.count - base, 18);
    chk(resCnt == 16 && rChan[15] == 4'd15, "R10 results unchanged", resCnt, 16);
    chk(doneCount == d0 + 1, "R10 single done", doneCount - d0, 1);

    // R12 divider
    halfPeriod = 8'd3;
    runScanCheck(16'h0001, 1);
    chk(lastHi == 3, "R12 half period 3", lastHi, 3);
    halfPeriod = 8'd1;
    runScanCheck(16'h8001, 2);
    chk(lastHi == 1, "R12 half period 1", lastHi, 1);
    chk(doneCyc - csRiseCyc == 2, "R13 done latency h1", doneCyc - csRiseCyc, 2);
    halfPeriod = 8'd0;
    runScanCheck(16'h0040, 1);
    chk(lastHi == 1, "R12 zero acts as one", lastHi, 1);
    halfPeriod = 8'(H);

    // R5 eight-bit variant
    d0 = done8Count; res8Cnt = 0; chanMask8 = 16'h0C00;
    @(negedge clk) scanStart8 = 1'b1;
    @(negedge clk) scanStart8 = 1'b0;
    guard = 0;
    while (done8Count <= d0 && guard < 20000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(res8Cnt == 2, "R5 eight-bit count", res8Cnt, 2);
    chk(r8Samp[0] == sampleOf(4'd10) >> 4, "R5 eight-bit ch10", r8Samp[0], sampleOf(4'd10) >> 4);
    chk(r8Samp[1] == sampleOf(4'd11) >> 4, "R5 eight-bit ch11", r8Samp[1], sampleOf(4'd11) >> 4);

    // R9 framing
    chk(mdl.badFrames == 0 && mdl8.badFrames == 0, "R9 sixteen clocks per frame", mdl.badFrames, 0);

    summary();
    $finish;
  end
endmodule